// File: doc/BRIEF.md
# Dual-Issue Pairing Check Unit

This unit sits in the issue stage of an in-order, two-wide processor front end. Every cycle it looks at two neighbouring 16-bit instruction slots: a preceding slot at a halfword address and a following slot at that address plus two. For each slot it gets a valid bit, a pre-decoded 3-bit group code, two source register indices, a destination index with a write flag, and a result latency. It then decides whether both slots issue, only the preceding one issues, or nothing issues.

A pair is allowed only when four things hold. The two group codes must be compatible. Both slots must lie in the same 1 KB page. Neither slot may touch a register that an earlier instruction is still writing. The following slot must not depend on the preceding slot's destination. Pending writes are tracked in a scoreboard, which holds one latency down-counter per register. When only the preceding slot goes, the front end is expected to shift the following instruction into the preceding position on the next cycle. A global stall blocks all issue. The scoreboard countdown keeps running during a stall.

Top module: `pair_issue_gate`

## Requirements
- R1: After synchronous reset both issue outputs are 0 and every register is free in the scoreboard.
- R2: Group codes are EX=0, MT=1, BR=2, LS=3, FE=4, CO=5. Among codes 0..4, a pair of equal groups is refused for EX, BR, LS and FE. MT pairs with any of 0..4, including MT. Every other mixed pair of codes 0..4 is allowed.
- R3: If either slot carries code 5 or above (CO, or an unused code), the pair is refused. A preceding slot with such a code may still issue alone.
- R4: A pair is allowed only if `pair_addr` and `pair_addr+2` agree in every bit from bit 10 upward. In other words, `pair_addr[9:1]` must not be all ones.
- R5: Nothing issues when `p_valid` is 0. The following slot issues only together with the preceding slot, and only if `f_valid` is 1.
- R6: If the preceding slot reads `p_src_a` or `p_src_b`, or writes `p_dst` (`p_wr`=1), and that register is busy in the scoreboard, nothing issues.
- R7: If the preceding slot is free but the following slot has such a scoreboard conflict, only the preceding slot issues.
- R8: A pair is refused when `p_wr`=1 and `p_dst` equals `f_src_a` or `f_src_b`. It is also refused when both slots write the same `p_dst`/`f_dst`.
- R9: An issued slot with its write flag set and latency L marks its destination busy for exactly the next L issue decisions. L=0 marks nothing.
- R10: While `stall` is 1, both issue outputs are 0 on the next cycle and no new scoreboard entry is set. Counters already running keep counting down.
- R11: Issue outputs are registered. The values seen after a clock edge reflect the inputs and scoreboard state sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Global stall: blocks issue and scoreboard sets |
| pair_addr | input | ADDR_W | Byte address of the preceding slot |
| p_valid | input | 1 | Preceding slot holds an instruction |
| p_grp | input | 3 | Preceding slot group code |
| p_src_a | input | $clog2(NREG) | Preceding slot first source register |
| p_src_b | input | $clog2(NREG) | Preceding slot second source register |
| p_dst | input | $clog2(NREG) | Preceding slot destination register |
| p_wr | input | 1 | Preceding slot writes p_dst |
| p_lat | input | LAT_W | Preceding slot result latency in cycles |
| f_valid | input | 1 | Following slot holds an instruction |
| f_grp | input | 3 | Following slot group code |
| f_src_a | input | $clog2(NREG) | Following slot first source register |
| f_src_b | input | $clog2(NREG) | Following slot second source register |
| f_dst | input | $clog2(NREG) | Following slot destination register |
| f_wr | input | 1 | Following slot writes f_dst |
| f_lat | input | LAT_W | Following slot result latency in cycles |
| issue_pre | output | 1 | Preceding slot issued (registered) |
| issue_fol | output | 1 | Following slot issued (registered) |

## Verification
Directed pairs walk the group matrix. Each refused same-group pair is placed next to an allowed MT/MT pair and mixed pairs, so that a matrix entry flipped either way shows up. Further directed pairs are placed on both sides of a page edge (0x3FC against 0x3FE), and CO is placed in each slot, to separate the page rule from the class rule. Scoreboard sequences confirm that a busy register blocks the preceding slot entirely but blocks the following slot alone. They also show that the busy window lasts exactly the latency given, and that stalling sets nothing while the countdown continues. After that, a long random run mixes addresses, groups, registers, latencies and stalls, and checks every cycle against a bench model.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int GRP_W = 3;
  localparam logic [GRP_W-1:0] GRP_EX = 3'd0;
  localparam logic [GRP_W-1:0] GRP_MT = 3'd1;
  localparam logic [GRP_W-1:0] GRP_BR = 3'd2;
  localparam logic [GRP_W-1:0] GRP_LS = 3'd3;
  localparam logic [GRP_W-1:0] GRP_FE = 3'd4;
  localparam logic [GRP_W-1:0] GRP_CO = 3'd5;
  // number of scoreboard lookups: 3 per slot
  localparam int N_LOOKUP = 6;
endpackage

// File: rtl/pair_class_matrix.sv
module pair_class_matrix
  import pair_pkg::*;
(
  input  logic [GRP_W-1:0] grp_pre,
  input  logic [GRP_W-1:0] grp_fol,
  output logic             compat
);
  logic pre_known, fol_known;

  always_comb begin
    pre_known = (grp_pre <= GRP_FE);
    fol_known = (grp_fol <= GRP_FE);
    compat    = 1'b0;
    if (pre_known && fol_known) begin
      if (grp_pre == GRP_MT || grp_fol == GRP_MT)
        compat = 1'b1;
      else
        compat = (grp_pre != grp_fol);
    end
  end
endmodule

// File: rtl/pair_page_check.sv
module pair_page_check #(
  parameter int ADDR_W  = 32,
  parameter int PAGE_LG = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              same_page
);
  logic [ADDR_W-1:0] next_addr;

  always_comb begin
    next_addr = addr + ADDR_W'(2);
    same_page = (addr[ADDR_W-1:PAGE_LG] == next_addr[ADDR_W-1:PAGE_LG]);
  end
endmodule

// File: rtl/pair_scoreboard.sv
module pair_scoreboard
  import pair_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int LAT_W = 2,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_LOOKUP-1:0][RIDX-1:0]  q_idx,
  output logic [N_LOOKUP-1:0]            q_busy,
  input  logic                           set0_en,
  input  logic [RIDX-1:0]                set0_idx,
  input  logic [LAT_W-1:0]               set0_lat,
  input  logic                           set1_en,
  input  logic [RIDX-1:0]                set1_idx,
  input  logic [LAT_W-1:0]               set1_lat
);
  logic [NREG-1:0] busy_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [LAT_W-1:0] cnt_r;
    always_ff @(posedge clk) begin
      if (rst)
        cnt_r <= '0;
      else if (set0_en && set0_idx == RIDX'(g))
        cnt_r <= set0_lat;
      else if (set1_en && set1_idx == RIDX'(g))
        cnt_r <= set1_lat;
      else if (cnt_r != '0)
        cnt_r <= cnt_r - 1'b1;
    end
    assign busy_vec[g] = (cnt_r != '0);
  end

  for (genvar q = 0; q < N_LOOKUP; q++) begin : g_look
    assign q_busy[q] = busy_vec[q_idx[q]];
  end
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate
  import pair_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PAGE_LG = 10,
  parameter int NREG    = 8,
  parameter int LAT_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stall,
  input  logic [ADDR_W-1:0]        pair_addr,
  input  logic                     p_valid,
  input  logic [2:0]               p_grp,
  input  logic [$clog2(NREG)-1:0]  p_src_a,
  input  logic [$clog2(NREG)-1:0]  p_src_b,
  input  logic [$clog2(NREG)-1:0]  p_dst,
  input  logic                     p_wr,
  input  logic [LAT_W-1:0]         p_lat,
  input  logic                     f_valid,
  input  logic [2:0]               f_grp,
  input  logic [$clog2(NREG)-1:0]  f_src_a,
  input  logic [$clog2(NREG)-1:0]  f_src_b,
  input  logic [$clog2(NREG)-1:0]  f_dst,
  input  logic                     f_wr,
  input  logic [LAT_W-1:0]         f_lat,
  output logic                     issue_pre,
  output logic                     issue_fol
);
  localparam int RIDX = $clog2(NREG);

  logic                          grp_ok, same_page;
  logic [N_LOOKUP-1:0][RIDX-1:0] q_idx;
  logic [N_LOOKUP-1:0]           q_busy;
  logic                          pre_hit, fol_hit, intra_dep;
  logic                          go_pre, go_fol;

  pair_class_matrix u_matrix (
    .grp_pre (p_grp),
    .grp_fol (f_grp),
    .compat  (grp_ok)
  );

  pair_page_check #(.ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG)) u_page (
    .addr      (pair_addr),
    .same_page (same_page)
  );

  always_comb begin
    q_idx[0] = p_src_a;
    q_idx[1] = p_src_b;
    q_idx[2] = p_dst;
    q_idx[3] = f_src_a;
    q_idx[4] = f_src_b;
    q_idx[5] = f_dst;
  end

  pair_scoreboard #(.NREG(NREG), .LAT_W(LAT_W)) u_sb (
    .clk      (clk),
    .rst      (rst),
    .q_idx    (q_idx),
    .q_busy   (q_busy),
    .set0_en  (go_pre && p_wr),
    .set0_idx (p_dst),
    .set0_lat (p_lat),
    .set1_en  (go_fol && f_wr),
    .set1_idx (f_dst),
    .set1_lat (f_lat)
  );

  always_comb begin
    pre_hit   = q_busy[0] || q_busy[1] || (p_wr && q_busy[2]);
    fol_hit   = q_busy[3] || q_busy[4] || (f_wr && q_busy[5]);
    intra_dep = p_wr && ((f_src_a == p_dst) || (f_src_b == p_dst) ||
                         (f_wr && f_dst == p_dst));
    go_pre    = !stall && p_valid && !pre_hit;
    go_fol    = go_pre && f_valid && grp_ok && same_page &&
                !fol_hit && !intra_dep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_pre <= 1'b0;
      issue_fol <= 1'b0;
    end else begin
      issue_pre <= go_pre;
      issue_fol <= go_fol;
    end
  end
endmodule

// File: rtl/pair_issue_gate_chk.sv
module pair_issue_gate_chk #(
  parameter int ADDR_W  = 32,
  parameter int PAGE_LG = 10,
  parameter int NREG    = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    stall,
  input logic [ADDR_W-1:0]       pair_addr,
  input logic                    p_valid,
  input logic [2:0]              p_grp,
  input logic [$clog2(NREG)-1:0] p_dst,
  input logic                    p_wr,
  input logic                    f_valid,
  input logic [2:0]              f_grp,
  input logic [$clog2(NREG)-1:0] f_src_a,
  input logic                    issue_pre,
  input logic                    issue_fol
);
  assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!issue_pre && !issue_fol));

  assert_fol_needs_pre_R5: assert property (@(posedge clk) disable iff (rst)
    issue_fol |-> issue_pre);

  assert_empty_pre_R5: assert property (@(posedge clk) disable iff (rst)
    !p_valid |=> !issue_pre);

  assert_co_alone_R3: assert property (@(posedge clk) disable iff (rst)
    ((p_valid && p_grp >= 3'd5) || (f_valid && f_grp >= 3'd5)) |=> !issue_fol);

  assert_page_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (pair_addr[PAGE_LG-1:1] == '1) |=> !issue_fol);

  assert_same_group_R2: assert property (@(posedge clk) disable iff (rst)
    (p_grp == f_grp && p_grp != 3'd1) |=> !issue_fol);

  assert_raw_inside_R8: assert property (@(posedge clk) disable iff (rst)
    (p_wr && f_src_a == p_dst) |=> !issue_fol);
endmodule

bind pair_issue_gate pair_issue_gate_chk #(
  .ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG), .NREG(NREG)
) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .pair_addr(pair_addr),
  .p_valid(p_valid), .p_grp(p_grp), .p_dst(p_dst), .p_wr(p_wr),
  .f_valid(f_valid), .f_grp(f_grp), .f_src_a(f_src_a),
  .issue_pre(issue_pre), .issue_fol(issue_fol)
);

// File: tb/test_pair_issue_gate.sv
module test_pair_issue_gate;
  localparam int NREG = 8;
  localparam int RW   = 3;
  localparam int LW   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic [31:0] pair_addr = 32'h100;
  logic p_valid = 0, p_wr = 0, f_valid = 0, f_wr = 0;
  logic [2:0] p_grp = 0, f_grp = 0;
  logic [RW-1:0] p_src_a = 0, p_src_b = 0, p_dst = 0;
  logic [RW-1:0] f_src_a = 0, f_src_b = 0, f_dst = 0;
  logic [LW-1:0] p_lat = 0, f_lat = 0;
  logic issue_pre, issue_fol;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  int mcnt [NREG];

  always #5 clk = ~clk;

  pair_issue_gate #(.ADDR_W(32), .PAGE_LG(10), .NREG(NREG), .LAT_W(LW)) i_pair_issue_gate (
    .clk(clk), .rst(rst), .stall(stall), .pair_addr(pair_addr),
    .p_valid(p_valid), .p_grp(p_grp), .p_src_a(p_src_a), .p_src_b(p_src_b),
    .p_dst(p_dst), .p_wr(p_wr), .p_lat(p_lat),
    .f_valid(f_valid), .f_grp(f_grp), .f_src_a(f_src_a), .f_src_b(f_src_b),
    .f_dst(f_dst), .f_wr(f_wr), .f_lat(f_lat),
    .issue_pre(issue_pre), .issue_fol(issue_fol)
  );

  function automatic bit grp_pairs(int a, int b);
    if (a > 4 || b > 4) return 0;
    if (a == 1 || b == 1) return 1;
    return a != b;
  endfunction

  function automatic bit busy(int r);
    return mcnt[r] != 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // e0/e1 < 0: use model result as expectation
  task automatic step(string tag, int e0, int e1);
    bit m0, m1, pg;
    logic [31:0] nxt;
    nxt = pair_addr + 32'd2;
    pg  = (pair_addr[31:10] == nxt[31:10]);
    m0 = !stall && p_valid &&
         !(busy(p_src_a) || busy(p_src_b) || (p_wr && busy(p_dst)));
    m1 = m0 && f_valid && grp_pairs(p_grp, f_grp) && pg &&
         !(busy(f_src_a) || busy(f_src_b) || (f_wr && busy(f_dst))) &&
         !(p_wr && (f_src_a == p_dst || f_src_b == p_dst || (f_wr && f_dst == p_dst)));
    for (int r = 0; r < NREG; r++) if (mcnt[r] != 0) mcnt[r]--;
    if (m0 && p_wr) mcnt[p_dst] = p_lat;
    if (m1 && f_wr) mcnt[f_dst] = f_lat;
    @(posedge clk);
    #1;
    check({tag, " issue_pre"}, issue_pre, (e0 < 0) ? m0 : e0);
    check({tag, " issue_fol"}, issue_fol, (e1 < 0) ? m1 : e1);
  endtask

  task automatic pre(bit v, int g, int a, int b, int d, bit w, int l);
    p_valid = v; p_grp = 3'(g); p_src_a = RW'(a); p_src_b = RW'(b);
    p_dst = RW'(d); p_wr = w; p_lat = LW'(l);
  endtask

  task automatic fol(bit v, int g, int a, int b, int d, bit w, int l);
    f_valid = v; f_grp = 3'(g); f_src_a = RW'(a); f_src_b = RW'(b);
    f_dst = RW'(d); f_wr = w; f_lat = LW'(l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NREG; r++) mcnt[r] = 0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1: reset state
    check("R1 issue_pre after reset", issue_pre, 0);
    check("R1 issue_fol after reset", issue_fol, 0);

    // R2: group matrix (EX=0 MT=1 BR=2 LS=3 FE=4)
    pair_addr = 32'h100;
    pre(1, 0, 1, 2, 3, 0, 0); fol(1, 1, 4, 5, 6, 0, 0); step("R2 EX/MT", 1, 1);
    pre(1, 0, 1, 2, 3, 0, 0); fol(1, 0, 4, 5, 6, 0, 0); step("R2 EX/EX", 1, 0);
    pre(1, 2, 1, 2, 3, 0, 0); fol(1, 2, 4, 5, 6, 0, 0); step("R2 BR/BR", 1, 0);
    pre(1, 3, 1, 2, 3, 0, 0); fol(1, 3, 4, 5, 6, 0, 0); step("R2 LS/LS", 1, 0);
    pre(1, 4, 1, 2, 3, 0, 0); fol(1, 4, 4, 5, 6, 0, 0); step("R2 FE/FE", 1, 0);
    pre(1, 1, 1, 2, 3, 0, 0); fol(1, 1, 4, 5, 6, 0, 0); step("R2 MT/MT", 1, 1);
    pre(1, 3, 1, 2, 3, 0, 0); fol(1, 2, 4, 5, 6, 0, 0); step("R2 LS/BR", 1, 1);
    pre(1, 4, 1, 2, 3, 0, 0); fol(1, 0, 4, 5, 6, 0, 0); step("R2 FE/EX", 1, 1);
    // R3: CO in either slot
    pre(1, 5, 1, 2, 3, 0, 0); fol(1, 0, 4, 5, 6, 0, 0); step("R3 CO/EX", 1, 0);
    pre(1, 0, 1, 2, 3, 0, 0); fol(1, 5, 4, 5, 6, 0, 0); step("R3 EX/CO", 1, 0);
    pre(1, 1, 1, 2, 3, 0, 0); fol(1, 7, 4, 5, 6, 0, 0); step("R3 MT/unused", 1, 0);
    // R4: page edge
    pair_addr = 32'h3FE;
    pre(1, 0, 1, 2, 3, 0, 0); fol(1, 1, 4, 5, 6, 0, 0); step("R4 edge 0x3FE", 1, 0);
    pair_addr = 32'h3FC; step("R4 inside 0x3FC", 1, 1);
    pair_addr = 32'h100;
    // R5: validity
    fol(0, 1, 4, 5, 6, 0, 0); step("R5 following invalid", 1, 0);
    pre(0, 0, 1, 2, 3, 0, 0); fol(1, 1, 4, 5, 6, 0, 0); step("R5 preceding invalid", 0, 0);
    // R6/R7/R9: scoreboard
    pre(1, 0, 1, 2, 7, 1, 3); fol(0, 1, 4, 5, 6, 0, 0); step("R9 set r7 lat3", 1, 0);
    pre(1, 0, 7, 2, 3, 0, 0); fol(1, 1, 4, 5, 6, 0, 0); step("R6 pre reads busy", 0, 0);
    pre(1, 0, 1, 2, 3, 0, 0); fol(1, 1, 7, 5, 6, 0, 0); step("R7 fol reads busy", 1, 0);
    step("R9 still busy 3rd", 1, 0);
    step("R9 freed after lat", 1, 1);
    // R8: dependence inside the pair
    pre(1, 0, 1, 2, 3, 1, 0); fol(1, 1, 3, 5, 6, 0, 0); step("R8 read after write", 1, 0);
    fol(1, 1, 4, 5, 3, 1, 0); step("R8 write after write", 1, 0);
    fol(1, 1, 4, 5, 6, 1, 0); step("R8 independent", 1, 1);
    // R10: stall
    stall = 1; pre(1, 0, 1, 2, 7, 1, 3); fol(1, 1, 4, 5, 6, 0, 0); step("R10 stall blocks", 0, 0);
    stall = 0; pre(1, 0, 7, 2, 3, 0, 0); step("R10 no set under stall", 1, 1);
    pre(1, 0, 1, 2, 7, 1, 2); fol(0, 1, 4, 5, 6, 0, 0); step("R10 set r7 lat2", 1, 0);
    stall = 1; step("R10 stall cycle 1", 0, 0);
    step("R10 stall cycle 2", 0, 0);
    stall = 0; pre(1, 0, 7, 2, 3, 0, 0); fol(1, 1, 4, 5, 6, 0, 0); step("R10 countdown ran", 1, 1);

    // R11: random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      pair_addr = $urandom & 32'hFFFF_FFFE;
      if ($urandom_range(0, 7) == 0) pair_addr[9:1] = '1;
      stall = ($urandom_range(0, 9) == 0);
      pre($urandom_range(0, 9) != 0, $urandom_range(0, 6), $urandom_range(0, 7),
          $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 1) == 1,
          $urandom_range(0, 3));
      fol($urandom_range(0, 9) != 0, $urandom_range(0, 6), $urandom_range(0, 7),
          $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 1) == 1,
          $urandom_range(0, 3));
      step("R11 random", -1, -1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule